// File: doc/BRIEF.md
# Bank-Spreading DRAM Address Mapper

This block turns a physical byte address into a DRAM location made of a bank number, a row (page) number and a column (offset within the page). Four mapping schemes can be picked per request with a 2-bit select. The first places consecutive cache lines in consecutive banks. The second places consecutive pages in consecutive banks. The third exchanges a few low cache-tag bits with the same number of top page-offset bits before slicing by page. The fourth slices by page and then XORs the bank field with the lowest cache-tag bits. Under the fourth scheme, addresses that collide in the same L2 set but have different tags spread over different banks, and the contents of each page stay together.

A request is a valid flag with an address and a mode. One register stage later the block presents the bank, row and column with a valid flag. When no request is offered, the outputs hold their last values. A separate combinational port gives the inverse of the XOR scheme: from a bank, row and column it rebuilds the original address. The widths of the address, block offset, page offset, bank field, L2 set index and swap group are all parameters.

Top module: `addr_bank_mapper`

## Requirements
- R1: Mode 0 (line). The bank is the BANK_W address bits directly above the block offset, starting at bit BLK_OFF_W. The address with those bits removed is split into a column (its low PAGE_OFF_W bits) and a row (the rest).
- R2: Mode 1 (page). The bank is address bits [PAGE_OFF_W +: BANK_W]. The column is the low PAGE_OFF_W bits. The row is every bit above the bank field.
- R3: Mode 2 (swap). Address bits [TAG_LO +: SWAP_W] trade places with bits [PAGE_OFF_W-SWAP_W +: SWAP_W], where TAG_LO = SET_W + BLK_OFF_W. The result is then split as in R2.
- R4: Mode 3 (XOR). Bank bit i equals address bit PAGE_OFF_W+i XOR address bit TAG_LO+i, for every i below BANK_W.
- R5: In mode 3, the row and column equal those of mode 2's neighbour scheme, mode 1, for the same address. All bytes of one page therefore land in one page.
- R6: The inverse port takes a bank, row and column and returns row, then (bank XOR the tag bits held in the row), then column, concatenated. Feeding it the mode-3 output of any address returns that address.
- R7: In mode 3, the 2^BANK_W addresses that differ only in bits [TAG_LO +: BANK_W] go to 2^BANK_W distinct banks.
- R8: In mode 3, 2^BANK_W consecutive pages inside one tag segment visit every bank exactly once.
- R9: out_valid is in_valid delayed by one clock. When in_valid is low, out_bank, out_row and out_col keep their previous values.
- R10: While rst_n is low, out_valid, out_bank, out_row and out_col are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_addr | input | ADDR_W | Physical address |
| in_mode | input | 2 | 0 line, 1 page, 2 swap, 3 XOR |
| out_valid | output | 1 | Registered result valid |
| out_bank | output | BANK_W | Bank number |
| out_row | output | ADDR_W-PAGE_OFF_W-BANK_W | Row number |
| out_col | output | PAGE_OFF_W | Offset inside the page |
| inv_bank | input | BANK_W | Bank for inverse lookup |
| inv_row | input | ADDR_W-PAGE_OFF_W-BANK_W | Row for inverse lookup |
| inv_col | input | PAGE_OFF_W | Column for inverse lookup |
| inv_addr | output | ADDR_W | Address rebuilt under the XOR scheme |

## Verification
A fixed table runs the same handful of addresses through all four modes. Addresses with distinct bits set below the block offset, in the bank field and in the tag show which slice each mode takes. Random addresses in XOR mode are pushed through the inverse port, which exposes any bit lost or misplaced in the forward or backward path. Two sweeps cover the spreading behaviour. One steps the low tag bits with the page fixed, the other steps whole pages with the tag fixed, and each requires every bank to appear once. A gap in the request stream shows whether the result registers hold.

// File: rtl/amap_pkg.sv
package amap_pkg;
  typedef enum logic [1:0] {
    MAP_LINE = 2'd0,
    MAP_PAGE = 2'd1,
    MAP_SWAP = 2'd2,
    MAP_PERM = 2'd3
  } map_mode_e;
endpackage

// File: rtl/amap_field_split.sv
module amap_field_split
  import amap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 3,
  parameter int SET_W      = 15,
  parameter int SWAP_W     = 2
) (
  input  logic [ADDR_W-1:0]                   addr_i,
  input  map_mode_e                           mode_i,
  output logic [BANK_W-1:0]                   bank_o,
  output logic [ADDR_W-PAGE_OFF_W-BANK_W-1:0] row_o,
  output logic [PAGE_OFF_W-1:0]               col_o
);
  localparam int ROW_W  = ADDR_W - PAGE_OFF_W - BANK_W;
  localparam int REST_W = ADDR_W - BANK_W;
  localparam int TAG_LO = SET_W + BLK_OFF_W;

  // page-style slice of any address
  function automatic logic [BANK_W-1:0] page_bank_of(input logic [ADDR_W-1:0] a);
    return a[PAGE_OFF_W +: BANK_W];
  endfunction

  function automatic logic [ROW_W-1:0] page_row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 : PAGE_OFF_W+BANK_W];
  endfunction

  // address with the line-interleave bank bits squeezed out
  function automatic logic [REST_W-1:0] line_rest_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1 : BLK_OFF_W+BANK_W], a[BLK_OFF_W-1:0]};
  endfunction

  logic [BANK_W-1:0]  line_bank, page_bank, tag_low, perm_bank, swap_bank;
  logic [REST_W-1:0]  line_rest;
  logic [ADDR_W-1:0]  swap_addr;

  assign line_bank = addr_i[BLK_OFF_W +: BANK_W];
  assign line_rest = line_rest_of(addr_i);
  assign page_bank = page_bank_of(addr_i);
  assign tag_low   = addr_i[TAG_LO +: BANK_W];
  assign perm_bank = page_bank ^ tag_low;

  generate
    if (SWAP_W > 0) begin : g_swap
      always_comb begin
        swap_addr = addr_i;
        swap_addr[TAG_LO +: SWAP_W]                = addr_i[PAGE_OFF_W-SWAP_W +: SWAP_W];
        swap_addr[PAGE_OFF_W-SWAP_W +: SWAP_W]     = addr_i[TAG_LO +: SWAP_W];
      end
    end else begin : g_noswap
      assign swap_addr = addr_i;
    end
  endgenerate

  assign swap_bank = page_bank_of(swap_addr);

  always_comb begin
    unique case (mode_i)
      MAP_LINE: begin
        bank_o = line_bank;
        row_o  = line_rest[REST_W-1 : PAGE_OFF_W];
        col_o  = line_rest[PAGE_OFF_W-1:0];
      end
      MAP_SWAP: begin
        bank_o = swap_bank;
        row_o  = page_row_of(swap_addr);
        col_o  = swap_addr[PAGE_OFF_W-1:0];
      end
      MAP_PERM: begin
        bank_o = perm_bank;
        row_o  = page_row_of(addr_i);
        col_o  = addr_i[PAGE_OFF_W-1:0];
      end
      default: begin
        bank_o = page_bank;
        row_o  = page_row_of(addr_i);
        col_o  = addr_i[PAGE_OFF_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/amap_out_reg.sv
module amap_out_reg #(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 18,
  parameter int COL_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic              valid_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      bank_o  <= '0;
      row_o   <= '0;
      col_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        bank_o <= bank_i;
        row_o  <= row_i;
        col_o  <= col_i;
      end
    end
  end

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> valid_o);
  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !valid_o);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(bank_o) && $stable(row_o) && $stable(col_o)));
endmodule

// File: rtl/amap_perm_inverse.sv
module amap_perm_inverse #(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 3,
  parameter int SET_W      = 15
) (
  input  logic [BANK_W-1:0]                   bank_i,
  input  logic [ADDR_W-PAGE_OFF_W-BANK_W-1:0] row_i,
  input  logic [PAGE_OFF_W-1:0]               col_i,
  output logic [ADDR_W-1:0]                   addr_o
);
  // tag bits sit above the bank field, so they survive inside the row
  localparam int TAG_IN_ROW = SET_W + BLK_OFF_W - PAGE_OFF_W - BANK_W;

  function automatic logic [BANK_W-1:0] undo_xor(
    input logic [BANK_W-1:0] b,
    input logic [ADDR_W-PAGE_OFF_W-BANK_W-1:0] r);
    return b ^ r[TAG_IN_ROW +: BANK_W];
  endfunction

  assign addr_o = {row_i, undo_xor(bank_i, row_i), col_i};
endmodule

// File: rtl/addr_bank_mapper.sv
module addr_bank_mapper
  import amap_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int BLK_OFF_W  = 6,
  parameter int PAGE_OFF_W = 11,
  parameter int BANK_W     = 3,
  parameter int SET_W      = 15,
  parameter int SWAP_W     = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic [ADDR_W-1:0]                   in_addr,
  input  logic [1:0]                          in_mode,
  output logic                                out_valid,
  output logic [BANK_W-1:0]                   out_bank,
  output logic [ADDR_W-PAGE_OFF_W-BANK_W-1:0] out_row,
  output logic [PAGE_OFF_W-1:0]               out_col,
  input  logic [BANK_W-1:0]                   inv_bank,
  input  logic [ADDR_W-PAGE_OFF_W-BANK_W-1:0] inv_row,
  input  logic [PAGE_OFF_W-1:0]               inv_col,
  output logic [ADDR_W-1:0]                   inv_addr
);
  localparam int ROW_W = ADDR_W - PAGE_OFF_W - BANK_W;

  map_mode_e         mode_e;
  logic [BANK_W-1:0] split_bank;
  logic [ROW_W-1:0]  split_row;
  logic [PAGE_OFF_W-1:0] split_col;
  logic [ADDR_W-1:0] roundtrip_addr;

  assign mode_e = map_mode_e'(in_mode);

  amap_field_split #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
    .BANK_W(BANK_W), .SET_W(SET_W), .SWAP_W(SWAP_W)
  ) u_split (
    .addr_i(in_addr), .mode_i(mode_e),
    .bank_o(split_bank), .row_o(split_row), .col_o(split_col)
  );

  amap_out_reg #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(PAGE_OFF_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .valid_i(in_valid),
    .bank_i(split_bank), .row_i(split_row), .col_i(split_col),
    .valid_o(out_valid), .bank_o(out_bank), .row_o(out_row), .col_o(out_col)
  );

  amap_perm_inverse #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
    .BANK_W(BANK_W), .SET_W(SET_W)
  ) u_inv (
    .bank_i(inv_bank), .row_i(inv_row), .col_i(inv_col), .addr_o(inv_addr)
  );

  // second inverse on the registered result, observed by the round-trip check
  amap_perm_inverse #(
    .ADDR_W(ADDR_W), .BLK_OFF_W(BLK_OFF_W), .PAGE_OFF_W(PAGE_OFF_W),
    .BANK_W(BANK_W), .SET_W(SET_W)
  ) u_inv_chk (
    .bank_i(out_bank), .row_i(out_row), .col_i(out_col), .addr_o(roundtrip_addr)
  );

  assert_perm_roundtrip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MAP_PERM) |=> (roundtrip_addr == $past(in_addr)));
  assert_page_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MAP_PAGE) |=> (out_bank == $past(in_addr[PAGE_OFF_W +: BANK_W])));
  assert_perm_keeps_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MAP_PERM) |=>
      (out_col == $past(in_addr[PAGE_OFF_W-1:0]) &&
       out_row == $past(in_addr[ADDR_W-1 : PAGE_OFF_W+BANK_W])));
  assert_line_bank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == MAP_LINE) |=> (out_bank == $past(in_addr[BLK_OFF_W +: BANK_W])));
endmodule

// File: tb/addr_bank_mapper_test.sv
module addr_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid;
  logic [2:0]  out_bank;
  logic [17:0] out_row;
  logic [10:0] out_col;
  logic [2:0]  inv_bank = '0;
  logic [17:0] inv_row = '0;
  logic [10:0] inv_col = '0;
  logic [31:0] inv_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr), .in_mode(in_mode),
    .out_valid(out_valid), .out_bank(out_bank), .out_row(out_row), .out_col(out_col),
    .inv_bank(inv_bank), .inv_row(inv_row), .inv_col(inv_col), .inv_addr(inv_addr)
  );

  // stimulus table {mode, address}
  localparam logic [33:0] VEC [10] = '{
    {2'd0, 32'h0000_0000}, {2'd0, 32'h0000_01C5}, {2'd0, 32'hDEAD_BEEF},
    {2'd1, 32'h0000_3800}, {2'd1, 32'h1234_5678},
    {2'd2, 32'h0060_0400}, {2'd2, 32'hCAFE_F00D},
    {2'd3, 32'h00E0_3800}, {2'd3, 32'h00A0_0800}, {2'd3, 32'h8765_4321}
  };

  // reference model written with division and remainder
  function automatic logic [31:0] model(input logic [1:0] m, input logic [31:0] a);
    logic [31:0] b, r, c, rest, t, h, x;
    case (m)
      2'd0: begin
        b = (a / 64) % 8;
        rest = (a / 512) * 64 + (a % 64);
        c = rest % 2048; r = rest / 2048;
      end
      2'd2: begin
        t = (a / 32'h20_0000) % 4; h = (a / 512) % 4;
        x = a - t * 32'h20_0000 - h * 512 + h * 32'h20_0000 + t * 512;
        b = (x / 2048) % 8; c = x % 2048; r = x / 16384;
      end
      2'd3: begin
        b = ((a / 2048) % 8) ^ ((a / 32'h20_0000) % 8);
        c = a % 2048; r = a / 16384;
      end
      default: begin
        b = (a / 2048) % 8; c = a % 2048; r = a / 16384;
      end
    endcase
    return {b[2:0], r[17:0], c[10:0]};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] m, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_mode = m; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    logic [7:0]  seen;
    logic [2:0]  held_bank;
    // R10 reset state
    repeat (3) @(negedge clk);
    check("R10", {out_valid, out_bank, out_row, out_col}, '0);
    rst_n = 1'b1;

    // table walk, R1 R2 R3 R4 R5 by mode
    for (int i = 0; i < 10; i++) begin
      send(VEC[i][33:32], VEC[i][31:0]);
      exp = model(VEC[i][33:32], VEC[i][31:0]);
      case (VEC[i][33:32])
        2'd0: check("R1", {out_bank, out_row, out_col}, exp);
        2'd1: check("R2", {out_bank, out_row, out_col}, exp);
        2'd2: check("R3", {out_bank, out_row, out_col}, exp);
        default: begin
          check("R4", out_bank, exp[31:29]);
          check("R5", {out_row, out_col}, {VEC[i][31:14], VEC[i][10:0]});
        end
      endcase
      check("R9", out_valid, 1'b1);
    end

    // R9 idle cycle holds outputs and drops valid
    held_bank = out_bank;
    @(negedge clk);
    check("R9", {out_valid, out_bank}, {1'b0, held_bank});

    // R6 inverse on random XOR-mode results
    for (int i = 0; i < 200; i++) begin
      logic [31:0] a;
      a = $urandom;
      send(2'd3, a);
      inv_bank = out_bank; inv_row = out_row; inv_col = out_col;
      #1;
      check("R6", inv_addr, a);
    end

    // R7 sweep low tag bits with page bits fixed
    seen = '0;
    for (int t = 0; t < 8; t++) begin
      send(2'd3, 32'h0500_2A00 | (t << 21));
      seen[out_bank] = 1'b1;
    end
    check("R7", seen, 8'hFF);

    // R8 consecutive pages inside one tag segment
    seen = '0;
    for (int p = 0; p < 8; p++) begin
      send(2'd3, 32'h00C0_0123 + (p * 2048));
      seen[out_bank] = 1'b1;
    end
    check("R8", seen, 8'hFF);

    // R10 reset again mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10", {out_valid, out_bank, out_row, out_col}, '0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule